// File: doc/BRIEF.md
# I2C Slave Receiver with Address Match

This block is the receive half of an I2C slave. It follows the bus through synchronised copies of SCL and SDA, spots START and STOP conditions, and shifts in the address byte that follows each START. If the 7-bit field equals the configured own address, it answers that address. If the field is all zeros and general-call answering is enabled, it answers the general call. It acknowledges only when the block is enabled, acknowledge is enabled and the direction bit is write. From then on it takes data bytes, MSB first. After each acknowledged address or data byte it raises an interrupt flag and posts a status code. It holds SCL low until software clears the flag.

Software drives the configuration inputs (enable, acknowledge enable, own address, general-call enable). It reads the flag, status code and last data byte, and clears the flag with a one-cycle strobe. A companion master can raise `lostArb` when it loses arbitration during an address phase. The slave then reports the distinct lost-arbitration codes for the address it accepted.

Top module: `i2cSlvRx`

## Requirements
- R1: After reset `irqFlag`, `sdaPull` and `sclHold` are 0 and `statusCode` is 8'hF8.
- R2: With `enable` and `ackEn` high, an address byte whose upper seven bits equal `ownAddr` and whose bit 0 is 0 is acknowledged (SDA low during the ninth SCL high). The flag is then set, status 8'h60 is posted and `sclHold` stays 1 until `flagClr` is pulsed.
- R3: An address byte of 8'h00 is acknowledged with status 8'h70 only when `gcEnable` is 1. With `gcEnable` 0 it gets no ACK and no flag.
- R4: An address byte whose upper bits match neither case, or whose bit 0 is 1 (read), gets no ACK, sets no flag and does not hold SCL.
- R5: With `ackEn` low when the eighth address bit ends, a matching own address is not acknowledged and no flag is set.
- R6: With `enable` low the block drives neither line and sets no flag, whatever the bus does.
- R7: After an accepted own address, each data byte is shifted in MSB first and copied to `rxData`. With `ackEn` high at the end of its eighth bit, it is acknowledged with status 8'h80. Otherwise it gets a NACK with status 8'h88, and the block then ignores the bus until the next START.
- R8: Data bytes after an accepted general call post 8'h90 (ACK) or 8'h98 (NACK).
- R9: If `lostArb` is 1 when an address is accepted, the posted status is 8'h68 for the own address and 8'h78 for the general call.
- R10: A STOP or repeated START seen while addressed sets the flag with status 8'hA0 and does not hold SCL. When not addressed, it sets no flag.
- R11: A status post takes effect SYNC_STAGES+1 clocks after the SDA or SCL change that causes it. When a post and `flagClr` fall in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| sclHold | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaPull | output | 1 | 1 pulls SDA low (acknowledge) |
| enable | input | 1 | Block enable |
| ackEn | input | 1 | Acknowledge enable |
| gcEnable | input | 1 | Answer the general call address |
| ownAddr | input | ADDR_W | Own 7-bit slave address |
| lostArb | input | 1 | Local master lost arbitration |
| flagClr | input | 1 | One-cycle strobe clearing the interrupt flag |
| irqFlag | output | 1 | Interrupt flag |
| statusCode | output | 8 | Last posted status code |
| rxData | output | ADDR_W+1 | Last received data byte |

## Verification
The clear strobe and a new status post can land in the same clock. This happens when software clears the flag just as a STOP is detected on a line that is not being stretched. The bench provokes it by closing an addressed transfer with a STOP and sweeping a one-cycle `flagClr` pulse across the clocks after the SDA rise. It expects the flag to be set for every pulse up to and including the post cycle, and clear for pulses after it. A dropped priority shows up as a clear flag exactly at the coincident offset.

// File: rtl/i2cSlvRxPkg.sv
`timescale 1ns/1ps
package i2cSlvRxPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_DATA,
    S_DACK
  } rxState_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic       shiftEn;
    logic       latchData;
    logic       post;
    logic       stretch;
    logic [7:0] code;
  } rxStrobe_t;

  localparam logic [7:0] ST_OWN_ACK   = 8'h60;
  localparam logic [7:0] ST_LOST_OWN  = 8'h68;
  localparam logic [7:0] ST_GC_ACK    = 8'h70;
  localparam logic [7:0] ST_LOST_GC   = 8'h78;
  localparam logic [7:0] ST_DATA_ACK  = 8'h80;
  localparam logic [7:0] ST_DATA_NACK = 8'h88;
  localparam logic [7:0] ST_GCD_ACK   = 8'h90;
  localparam logic [7:0] ST_GCD_NACK  = 8'h98;
  localparam logic [7:0] ST_STOP      = 8'hA0;
  localparam logic [7:0] ST_NONE      = 8'hF8;

endpackage

// File: rtl/i2cSlvRxPath.sv
`timescale 1ns/1ps
module i2cSlvRxPath
  import i2cSlvRxPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  rxStrobe_t       stb,
  input  logic            flagClr,
  output logic            sclRise,
  output logic            sclFall,
  output logic            startEv,
  output logic            stopEv,
  output logic [ADDR_W:0] shiftData,
  output logic [ADDR_W:0] rxData,
  output logic [7:0]      statusCode,
  output logic            irqFlag,
  output logic            sclHold
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftData <= '0;
      rxData    <= '0;
    end else begin
      if (stb.shiftEn)   shiftData <= {shiftData[ADDR_W-1:0], sdaS};
      if (stb.latchData) rxData    <= shiftData;
    end
  end

  // a post in the same clock as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag    <= 1'b0;
      sclHold    <= 1'b0;
      statusCode <= ST_NONE;
    end else if (stb.post) begin
      irqFlag    <= 1'b1;
      sclHold    <= stb.stretch;
      statusCode <= stb.code;
    end else if (flagClr) begin
      irqFlag <= 1'b0;
      sclHold <= 1'b0;
    end
  end

  p_post_sets_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.post |=> (irqFlag && statusCode == $past(stb.code)));

  p_clear_drops_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !stb.post) |=> (!irqFlag && !sclHold));

  p_hold_needs_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclHold |-> irqFlag);

endmodule

// File: rtl/i2cSlvRxCtl.sv
`timescale 1ns/1ps
module i2cSlvRxCtl
  import i2cSlvRxPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              ackEn,
  input  logic              gcEnable,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              lostArb,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic [ADDR_W:0]   shiftData,
  output rxStrobe_t         stb,
  output logic              sdaPull
);

  localparam int CNT_W = $clog2(ADDR_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W + 1);

  rxState_e         state, stateN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic gcMode, gcN, lostMode, lostN, addressed, addrdN, ackDec, ackDN, pullN;
  logic isGc, hitOwn, hitGc, accept;

  assign isGc   = (shiftData[ADDR_W:1] == '0);
  assign hitOwn = !isGc && (shiftData[ADDR_W:1] == ownAddr);
  assign hitGc  = isGc && gcEnable;
  assign accept = (hitOwn || hitGc) && !shiftData[0] && ackEn;

  always_comb begin
    stateN = state;
    cntN   = bitCnt;
    gcN    = gcMode;
    lostN  = lostMode;
    addrdN = addressed;
    ackDN  = ackDec;
    pullN  = sdaPull;
    stb    = '0;
    if (!enable) begin
      stateN = S_IDLE;
      addrdN = 1'b0;
      pullN  = 1'b0;
    end else if (startEv || stopEv) begin
      if (addressed) begin
        stb.post = 1'b1;
        stb.code = ST_STOP;
      end
      addrdN = 1'b0;
      pullN  = 1'b0;
      cntN   = '0;
      stateN = startEv ? S_ADDR : S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_DATA: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            stb.shiftEn = 1'b1;
            cntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            if (state == S_ADDR) begin
              if (accept) begin
                stateN = S_AACK;
                pullN  = 1'b1;
                gcN    = isGc;
                lostN  = lostArb;
              end else begin
                stateN = S_IDLE;
              end
            end else begin
              stateN = S_DACK;
              pullN  = ackEn;
              ackDN  = ackEn;
            end
          end
        end
        S_AACK: if (sclFall) begin
          pullN       = 1'b0;
          stateN      = S_DATA;
          cntN        = '0;
          addrdN      = 1'b1;
          stb.post    = 1'b1;
          stb.stretch = 1'b1;
          stb.code    = gcMode ? (lostMode ? ST_LOST_GC : ST_GC_ACK)
                               : (lostMode ? ST_LOST_OWN : ST_OWN_ACK);
        end
        S_DACK: if (sclFall) begin
          pullN         = 1'b0;
          cntN          = '0;
          stb.post      = 1'b1;
          stb.stretch   = 1'b1;
          stb.latchData = 1'b1;
          stb.code      = gcMode ? (ackDec ? ST_GCD_ACK : ST_GCD_NACK)
                                 : (ackDec ? ST_DATA_ACK : ST_DATA_NACK);
          if (ackDec) begin
            stateN = S_DATA;
          end else begin
            stateN = S_IDLE;
            addrdN = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      gcMode    <= 1'b0;
      lostMode  <= 1'b0;
      addressed <= 1'b0;
      ackDec    <= 1'b0;
      sdaPull   <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= cntN;
      gcMode    <= gcN;
      lostMode  <= lostN;
      addressed <= addrdN;
      ackDec    <= ackDN;
      sdaPull   <= pullN;
    end
  end

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sdaPull && state == S_IDLE));

  p_ack_only_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AACK) |-> !shiftData[0]);

  p_ack_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AACK && $past(state) == S_ADDR) |-> $past(ackEn));

endmodule

// File: rtl/i2cSlvRx.sv
`timescale 1ns/1ps
module i2cSlvRx
  import i2cSlvRxPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclHold,
  output logic              sdaPull,
  input  logic              enable,
  input  logic              ackEn,
  input  logic              gcEnable,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              lostArb,
  input  logic              flagClr,
  output logic              irqFlag,
  output logic [7:0]        statusCode,
  output logic [ADDR_W:0]   rxData
);

  rxStrobe_t       stb;
  logic            sclRise, sclFall, startEv, stopEv;
  logic [ADDR_W:0] shiftData;

  i2cSlvRxPath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .flagClr(flagClr), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .shiftData(shiftData),
    .rxData(rxData), .statusCode(statusCode), .irqFlag(irqFlag),
    .sclHold(sclHold)
  );

  i2cSlvRxCtl #(.ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .ackEn(ackEn),
    .gcEnable(gcEnable), .ownAddr(ownAddr), .lostArb(lostArb),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv),
    .stopEv(stopEv), .shiftData(shiftData), .stb(stb), .sdaPull(sdaPull)
  );

endmodule

// File: tb/sim_i2cSlvRx.sv
`timescale 1ns/1ps
module sim_i2cSlvRx;

  localparam int H = 10;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclBus, sdaBus, sclHold, sdaPull;
  logic cfgEn = 1'b1, cfgAck = 1'b1, cfgGc = 1'b0, cfgLost = 1'b0, flagClr = 1'b0;
  logic [6:0] cfgOwn = 7'h2A;
  logic irqFlag;
  logic [7:0] statusCode, rxData;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  assign sclBus = mScl & ~sclHold;
  assign sdaBus = mSda & ~sdaPull;

  i2cSlvRx u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclHold(sclHold), .sdaPull(sdaPull), .enable(cfgEn), .ackEn(cfgAck),
    .gcEnable(cfgGc), .ownAddr(cfgOwn), .lostArb(cfgLost), .flagClr(flagClr),
    .irqFlag(irqFlag), .statusCode(statusCode), .rxData(rxData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addrExp(input logic [7:0] ab);
    if (!cfgEn || !cfgAck || ab[0]) return 8'h00;
    if (ab[7:1] == 7'h0) return cfgGc ? (cfgLost ? 8'h78 : 8'h70) : 8'h00;
    if (ab[7:1] == cfgOwn) return cfgLost ? 8'h68 : 8'h60;
    return 8'h00;
  endfunction

  function automatic logic [7:0] dataExp(input logic gc, input logic ack);
    if (gc) return ack ? 8'h90 : 8'h98;
    return ack ? 8'h80 : 8'h88;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raiseScl();
    mScl = 1'b1;
    @(negedge clk);
    while (!sclBus) @(negedge clk);
  endtask

  task automatic startC();
    mSda = 1'b1; tick(H);
    raiseScl(); tick(H);
    mSda = 1'b0; tick(H);
    mScl = 1'b0; tick(H);
  endtask

  task automatic stopC();
    mSda = 1'b0; tick(H);
    raiseScl(); tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = v[i]; tick(H);
      raiseScl(); tick(H);
      mScl = 1'b0; tick(H);
    end
    mSda = 1'b1; tick(H);
    raiseScl(); tick(H/2);
    acked = !sdaBus;
    tick(H/2);
    mScl = 1'b0; tick(H);
  endtask

  task automatic clrFlag();
    flagClr = 1'b1; @(negedge clk);
    flagClr = 1'b0; tick(2);
  endtask

  task automatic doTx(input logic [7:0] ab, input int nData, input logic randAck);
    logic [7:0] exp, dv;
    logic acked, gc, addrd;
    string tg;
    exp = addrExp(ab);
    gc  = (ab[7:1] == 7'h0);
    tg  = (exp != 0) ? (cfgLost ? "R9" : (gc ? "R3" : "R2")) : (!cfgEn ? "R6" : (!cfgAck ? "R5" : "R4"));
    startC();
    sendByte(ab, acked);
    chk({tg, " address ack"}, acked, exp != 0);
    chk({tg, " address flag"}, irqFlag, exp != 0);
    chk({tg, " scl hold"}, sclHold, exp != 0);
    chk({tg, " no sda drive after ack"}, sdaPull, 0);
    addrd = (exp != 0);
    if (addrd) begin
      chk({tg, " address status"}, statusCode, exp);
      clrFlag();
      chk("R2 hold released by clear", sclHold, 0);
      for (int k = 0; k < nData; k++) begin
        if (randAck) cfgAck = ($urandom_range(0, 4) != 0);
        dv = 8'($urandom);
        sendByte(dv, acked);
        chk(gc ? "R8 data ack" : "R7 data ack", acked, cfgAck);
        chk(gc ? "R8 data flag" : "R7 data flag", irqFlag, 1);
        chk(gc ? "R8 data status" : "R7 data status", statusCode, dataExp(gc, cfgAck));
        chk("R7 data value", rxData, dv);
        clrFlag();
        if (!cfgAck) begin
          addrd = 1'b0;
          break;
        end
      end
    end
    stopC();
    tick(4);
    chk("R10 stop flag", irqFlag, addrd);
    chk("R10 stop no hold", sclHold, 0);
    if (addrd) begin
      chk("R10 stop status", statusCode, 8'hA0);
      clrFlag();
    end
    cfgAck = 1'b1;
    tick(H);
  endtask

  initial begin
    logic a;
    void'($urandom(32'd7345));
    tick(5);
    rstN = 1'b1;
    tick(3);
    chk("R1 flag", irqFlag, 0);
    chk("R1 status", statusCode, 8'hF8);
    chk("R1 sda", sdaPull, 0);
    chk("R1 scl", sclHold, 0);

    doTx({7'h2A, 1'b0}, 2, 1'b0);
    cfgGc = 1'b1; doTx(8'h00, 2, 1'b0);
    cfgGc = 1'b0; doTx(8'h00, 0, 1'b0);
    doTx({7'h2B, 1'b0}, 0, 1'b0);
    doTx({7'h2A, 1'b1}, 0, 1'b0);
    cfgAck = 1'b0; doTx({7'h2A, 1'b0}, 0, 1'b0);
    cfgEn = 1'b0; doTx({7'h2A, 1'b0}, 0, 1'b0); cfgEn = 1'b1;
    cfgLost = 1'b1; doTx({7'h2A, 1'b0}, 1, 1'b0);
    cfgGc = 1'b1; doTx(8'h00, 1, 1'b0); cfgGc = 1'b0; cfgLost = 1'b0;

    // R7: NACKed byte, then the block ignores the bus until START
    startC();
    sendByte({7'h2A, 1'b0}, a);
    clrFlag();
    cfgAck = 1'b0;
    sendByte(8'h3C, a);
    chk("R7 nack", a, 0);
    chk("R7 nack status", statusCode, 8'h88);
    chk("R7 nack data", rxData, 8'h3C);
    clrFlag();
    cfgAck = 1'b1;
    sendByte(8'h11, a);
    chk("R7 ignored after nack ack", a, 0);
    chk("R7 ignored after nack flag", irqFlag, 0);
    stopC(); tick(4);
    chk("R10 no flag when idle", irqFlag, 0);

    // R10: repeated START while addressed
    startC();
    sendByte({7'h2A, 1'b0}, a);
    clrFlag();
    startC();
    chk("R10 restart flag", irqFlag, 1);
    chk("R10 restart status", statusCode, 8'hA0);
    chk("R10 restart no hold", sclHold, 0);
    clrFlag();
    sendByte({7'h2A, 1'b0}, a);
    chk("R2 after restart", statusCode, 8'h60);
    clrFlag();
    stopC(); tick(4); clrFlag(); tick(H);

    // R11: clear pulse swept across the STOP post cycle
    for (int j = 1; j <= 5; j++) begin
      startC();
      sendByte({7'h2A, 1'b0}, a);
      clrFlag();
      mSda = 1'b0; tick(H);
      raiseScl(); tick(H);
      @(negedge clk);
      mSda = 1'b1;
      repeat (j - 1) @(negedge clk);
      flagClr = 1'b1;
      @(negedge clk);
      flagClr = 1'b0;
      tick(8);
      chk($sformatf("R11 set beats clear offset %0d", j), irqFlag, (j <= LAT));
      clrFlag(); tick(H);
    end

    // random transactions
    for (int t = 0; t < 36; t++) begin
      int sel;
      logic [7:0] ab;
      sel = $urandom_range(0, 99);
      cfgOwn = 7'($urandom_range(1, 127));
      cfgGc = $urandom_range(0, 1) == 1;
      cfgAck = $urandom_range(0, 7) != 0;
      cfgLost = $urandom_range(0, 4) == 0;
      if (sel < 40)      ab = {cfgOwn, 1'b0};
      else if (sel < 55) ab = {cfgOwn, 1'b1};
      else if (sel < 75) ab = 8'h00;
      else               ab = 8'($urandom);
      doTx(ab, $urandom_range(0, 3), 1'b1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule